// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block chooses the low-power state of a small processor and drives the matching control lines: CPU halt, system clock enable, peripheral reset, a retention flag for registers and RAM, and an I/O hold flag. Software requests a low-power state by pulsing `sleep_i` for one cycle when the core executes its sleep instruction. At that moment three control bits pick the target: a standby-select bit, a low-speed-enable bit and a watchdog prescaler-select bit. The target is either light sleep, where the clock keeps running, or software standby, where the clock stops and the ports freeze. A generic wake event brings the block back to running.

Separately, an asynchronous active-low standby pin forces hardware standby. The pin passes through a synchronizer and then overrides every software-selected state. It halts the core, stops the clock and holds the peripherals in reset. When the pin returns high the block resumes running, and the peripheral reset is released one cycle after that. A 2-bit status output reports the current mode.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: A synchronous active-high reset `rst_i` puts the block in running mode: `mode_o`=00, `cpu_halt_o`=0, `sys_clk_en_o`=1, `periph_rst_o`=0, `retain_o`=0, `io_hold_o`=0.
- R2: When running, a `sleep_i` pulse with `stby_sel_i`=0 and `lowspd_en_i`=0 gives sleep on the next clock edge: `mode_o`=01, `cpu_halt_o`=1, `sys_clk_en_o`=1, `retain_o`=1, `io_hold_o`=0, `periph_rst_o`=0.
- R3: When running, a `sleep_i` pulse with `stby_sel_i`=1, `lowspd_en_i`=0 and `wdt_psel_i`=0 gives software standby on the next edge: `mode_o`=10, `cpu_halt_o`=1, `sys_clk_en_o`=0, `retain_o`=1, `io_hold_o`=1, `periph_rst_o`=0.
- R4: When running, a `sleep_i` pulse with `lowspd_en_i`=1, or with `stby_sel_i`=1 and `wdt_psel_i`=1, leaves the block running (`mode_o`=00).
- R5: A `sleep_i` pulse while in sleep, software standby or hardware standby leaves `mode_o` unchanged.
- R6: `wake_i` high in sleep or software standby returns the block to running on the next edge, with the halt release and the clock enable restore in that same cycle.
- R7: `hstby_n_i` held low yields hardware standby on the third clock edge after the change, from any mode and for any control bits: `mode_o`=11, `cpu_halt_o`=1, `sys_clk_en_o`=0, `periph_rst_o`=1, `retain_o`=1, `io_hold_o`=0.
- R8: Hardware standby ignores `wake_i`. On the third edge after `hstby_n_i` returns high the block is running with `periph_rst_o` still 1, and `periph_rst_o` falls on the following edge.
- R9: `wake_i` while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | One-cycle pulse from the sleep instruction |
| stby_sel_i | input | 1 | Standby-select control bit |
| lowspd_en_i | input | 1 | Low-speed-enable control bit |
| wdt_psel_i | input | 1 | Watchdog prescaler-select bit |
| hstby_n_i | input | 1 | Asynchronous active-low hardware standby pin |
| wake_i | input | 1 | Wake-up event |
| cpu_halt_o | output | 1 | Halts the CPU |
| sys_clk_en_o | output | 1 | System clock enable |
| periph_rst_o | output | 1 | Reset to supporting peripherals |
| retain_o | output | 1 | Register/RAM retention flag |
| io_hold_o | output | 1 | Hold the I/O ports in their present state |
| mode_o | output | 2 | Current mode: 00 run, 01 sleep, 10 software standby, 11 hardware standby |

## Verification
The properties treat the synchronized pin level as the cause of hardware standby. They therefore assume that `hstby_n_i` stays at one level long enough to cross the synchronizer, and that the control bits are steady in the cycle `sleep_i` is sampled. The stimulus drives every input half a cycle away from the sampling edge. It holds each pin level for at least four cycles and draws the control bits freshly each cycle, so every decode combination meets a sleep pulse.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        LPM_RUN   = 2'b00,
        LPM_SLEEP = 2'b01,
        LPM_SSTBY = 2'b10,
        LPM_HSTBY = 2'b11
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      prst_tail;
    } lpm_state_t;

    typedef struct packed {
        logic cpu_halt;
        logic clk_en;
        logic periph_rst;
        logic retain;
        logic io_hold;
    } lpm_ctl_t;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[LAST-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) sh_q <= {STAGES{RST_VAL}};
        else       sh_q <= sh_d;
    end

    assign q_o = sh_q[LAST];
endmodule

// File: rtl/lpm_decode.sv
module lpm_decode
    import lpm_pkg::*;
(
    input  logic      sleep_i,
    input  logic      stby_sel_i,
    input  logic      lowspd_en_i,
    input  logic      wdt_psel_i,
    output logic      req_vld_o,
    output lpm_mode_e req_mode_o
);
    always_comb begin
        req_vld_o  = 1'b0;
        req_mode_o = LPM_RUN;
        if (sleep_i && !lowspd_en_i) begin
            if (!stby_sel_i) begin
                req_vld_o  = 1'b1;
                req_mode_o = LPM_SLEEP;
            end else if (!wdt_psel_i) begin
                req_vld_o  = 1'b1;
                req_mode_o = LPM_SSTBY;
            end
        end
    end
endmodule

// File: rtl/lpm_outmap.sv
module lpm_outmap
    import lpm_pkg::*;
(
    input  lpm_state_t st_i,
    output lpm_ctl_t   ctl_o
);
    always_comb begin
        ctl_o = '{cpu_halt: 1'b0, clk_en: 1'b1, periph_rst: st_i.prst_tail,
                  retain: 1'b0, io_hold: 1'b0};
        unique case (st_i.mode)
            LPM_RUN: ;
            LPM_SLEEP: begin
                ctl_o.cpu_halt = 1'b1;
                ctl_o.retain   = 1'b1;
            end
            LPM_SSTBY: begin
                ctl_o.cpu_halt = 1'b1;
                ctl_o.clk_en   = 1'b0;
                ctl_o.retain   = 1'b1;
                ctl_o.io_hold  = 1'b1;
            end
            LPM_HSTBY: begin
                ctl_o.cpu_halt   = 1'b1;
                ctl_o.clk_en     = 1'b0;
                ctl_o.retain     = 1'b1;
                ctl_o.periph_rst = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
    import lpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sleep_i,
    input  logic              stby_sel_i,
    input  logic              lowspd_en_i,
    input  logic              wdt_psel_i,
    input  logic              hstby_n_i,
    input  logic              wake_i,
    output logic              cpu_halt_o,
    output logic              sys_clk_en_o,
    output logic              periph_rst_o,
    output logic              retain_o,
    output logic              io_hold_o,
    output logic [MODE_W-1:0] mode_o
);
    logic       pin_sync;
    logic       hs_req;
    logic       req_vld;
    lpm_mode_e  req_mode;
    lpm_state_t st_d, st_q;
    lpm_ctl_t   ctl;

    lpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (hstby_n_i),
        .q_o   (pin_sync)
    );

    assign hs_req = ~pin_sync;

    lpm_decode u_dec (
        .sleep_i     (sleep_i),
        .stby_sel_i  (stby_sel_i),
        .lowspd_en_i (lowspd_en_i),
        .wdt_psel_i  (wdt_psel_i),
        .req_vld_o   (req_vld),
        .req_mode_o  (req_mode)
    );

    always_comb begin
        st_d           = st_q;
        st_d.prst_tail = 1'b0;
        if (hs_req) begin
            st_d.mode = LPM_HSTBY;
        end else begin
            unique case (st_q.mode)
                LPM_HSTBY: begin
                    st_d.mode      = LPM_RUN;
                    st_d.prst_tail = 1'b1;
                end
                LPM_RUN: begin
                    if (req_vld) st_d.mode = req_mode;
                end
                LPM_SLEEP, LPM_SSTBY: begin
                    if (wake_i) st_d.mode = LPM_RUN;
                end
                default: st_d.mode = LPM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '{mode: LPM_RUN, prst_tail: 1'b0};
        else       st_q <= st_d;
    end

    lpm_outmap u_map (
        .st_i  (st_q),
        .ctl_o (ctl)
    );

    assign cpu_halt_o   = ctl.cpu_halt;
    assign sys_clk_en_o = ctl.clk_en;
    assign periph_rst_o = ctl.periph_rst;
    assign retain_o     = ctl.retain;
    assign io_hold_o    = ctl.io_hold;
    assign mode_o       = st_q.mode;
endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       sleep_i,
    input logic       stby_sel_i,
    input logic       lowspd_en_i,
    input logic       wdt_psel_i,
    input logic       wake_i,
    input logic       hs_req,
    input logic       cpu_halt_o,
    input logic       sys_clk_en_o,
    input logic       periph_rst_o,
    input logic [1:0] mode_o
);
    // R2
    sleep_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 && sleep_i && !stby_sel_i && !lowspd_en_i && !hs_req)
        |=> (mode_o == 2'b01 && cpu_halt_o && sys_clk_en_o));

    // R3
    sstby_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 && sleep_i && stby_sel_i && !lowspd_en_i && !wdt_psel_i && !hs_req)
        |=> (mode_o == 2'b10 && cpu_halt_o && !sys_clk_en_o));

    // R4
    bad_combo_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 && sleep_i && (lowspd_en_i || (stby_sel_i && wdt_psel_i)) && !hs_req)
        |=> (mode_o == 2'b00));

    // R5
    no_reentry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o != 2'b00 && !wake_i && !hs_req && mode_o != 2'b11) |=> $stable(mode_o));

    // R6
    wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mode_o == 2'b01 || mode_o == 2'b10) && wake_i && !hs_req)
        |=> (mode_o == 2'b00 && !cpu_halt_o && sys_clk_en_o));

    // R7
    hs_enter_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hs_req |=> (mode_o == 2'b11 && periph_rst_o && !sys_clk_en_o));

    // R8
    hs_leave_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b11 && !hs_req) |=> (mode_o == 2'b00 && periph_rst_o));

    // R8
    prst_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 && periph_rst_o && !hs_req) |=> !periph_rst_o);

    // R9
    run_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'b00 && wake_i && !sleep_i && !hs_req) |=> (mode_o == 2'b00));
endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sleep_i      (sleep_i),
    .stby_sel_i   (stby_sel_i),
    .lowspd_en_i  (lowspd_en_i),
    .wdt_psel_i   (wdt_psel_i),
    .wake_i       (wake_i),
    .hs_req       (hs_req),
    .cpu_halt_o   (cpu_halt_o),
    .sys_clk_en_o (sys_clk_en_o),
    .periph_rst_o (periph_rst_o),
    .mode_o       (mode_o)
);

// File: tb/lpm_entry_ctrl_tb.sv
`timescale 1ns/100ps
module lpm_entry_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep = 1'b0, ssel = 1'b0, lson = 1'b0, psel = 1'b0, pin_n = 1'b1, wake = 1'b0;
    logic halt, clken, prst, ret, hold;
    logic [1:0] mode;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lpm_entry_ctrl u_dut (
        .clk_i (clk), .rst_i (rst), .sleep_i (sleep), .stby_sel_i (ssel),
        .lowspd_en_i (lson), .wdt_psel_i (psel), .hstby_n_i (pin_n), .wake_i (wake),
        .cpu_halt_o (halt), .sys_clk_en_o (clken), .periph_rst_o (prst),
        .retain_o (ret), .io_hold_o (hold), .mode_o (mode)
    );

    // expected output vector {mode, halt, clk_en, prst, retain, hold}
    function automatic logic [6:0] exp_vec(logic [1:0] m, logic tail);
        case (m)
            2'b00:   return {2'b00, 1'b0, 1'b1, tail, 1'b0, 1'b0};
            2'b01:   return {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
            2'b10:   return {2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            default: return {2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        endcase
    endfunction

    function automatic logic [1:0] nxt_mode(logic [1:0] m, logic hs, logic sl,
                                            logic ss, logic ls, logic ps, logic wk);
        if (hs) return 2'b11;
        if (m == 2'b11) return 2'b00;
        if (m == 2'b00) begin
            if (sl && !ls && !ss) return 2'b01;
            if (sl && !ls && ss && !ps) return 2'b10;
            return 2'b00;
        end
        if (wk) return 2'b00;
        return m;
    endfunction

    function automatic string tag_of(logic [1:0] m);
        case (m)
            2'b00:   return "R1/R4/R9";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R7";
        endcase
    endfunction

    // bench reference model
    logic s1_m, s2_m, tail_m;
    logic [1:0] m_m;
    always @(posedge clk) begin
        if (rst) begin
            s1_m <= 1'b1; s2_m <= 1'b1; m_m <= 2'b00; tail_m <= 1'b0;
        end else begin
            s1_m   <= pin_n;
            s2_m   <= s1_m;
            m_m    <= nxt_mode(m_m, !s2_m, sleep, ssel, lson, psel, wake);
            tail_m <= (m_m == 2'b11) && s2_m;
        end
    end

    task automatic chk(string tag, logic [6:0] expv);
        logic [6:0] act;
        act = {mode, halt, clken, prst, ret, hold};
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, expv);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep(logic s, logic l, logic p);
        ssel = s; lson = l; psel = p; sleep = 1'b1;
        cyc();
        sleep = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        cyc();
        wake = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hold_cnt;
        void'($urandom(32'd20240611));
        cyc(3);
        rst = 1'b0;
        cyc();
        chk("R1 reset state", 7'b00_0_1_0_0_0);

        pulse_sleep(1'b0, 1'b0, 1'b1);
        chk("R2 sleep entry", 7'b01_1_1_0_1_0);
        pulse_sleep(1'b1, 1'b0, 1'b0);
        chk("R5 sleep pulse in sleep", 7'b01_1_1_0_1_0);
        pulse_wake();
        chk("R6 wake from sleep", 7'b00_0_1_0_0_0);

        pulse_sleep(1'b1, 1'b0, 1'b0);
        chk("R3 software standby entry", 7'b10_1_0_0_1_1);
        pulse_sleep(1'b0, 1'b0, 1'b0);
        chk("R5 sleep pulse in standby", 7'b10_1_0_0_1_1);
        pulse_wake();
        chk("R6 wake from software standby", 7'b00_0_1_0_0_0);

        pulse_sleep(1'b0, 1'b1, 1'b0);
        chk("R4 low-speed set", 7'b00_0_1_0_0_0);
        pulse_sleep(1'b1, 1'b0, 1'b1);
        chk("R4 prescaler-select set", 7'b00_0_1_0_0_0);
        pulse_wake();
        chk("R9 wake while running", 7'b00_0_1_0_0_0);

        pulse_sleep(1'b0, 1'b0, 1'b0);
        pin_n = 1'b0;
        cyc();
        chk("R7 pin edge 1", 7'b01_1_1_0_1_0);
        cyc();
        chk("R7 pin edge 2", 7'b01_1_1_0_1_0);
        cyc();
        chk("R7 hardware standby", 7'b11_1_0_1_1_0);
        pulse_wake();
        chk("R8 wake ignored in hw standby", 7'b11_1_0_1_1_0);
        pulse_sleep(1'b1, 1'b0, 1'b0);
        chk("R5 sleep pulse in hw standby", 7'b11_1_0_1_1_0);
        pin_n = 1'b1;
        cyc(2);
        chk("R8 still in hw standby", 7'b11_1_0_1_1_0);
        cyc();
        chk("R8 running, reset held", 7'b00_0_1_1_0_0);
        cyc();
        chk("R8 reset released", 7'b00_0_1_0_0_0);

        pulse_sleep(1'b1, 1'b0, 1'b0);
        pin_n = 1'b0;
        cyc(3);
        chk("R7 override of software standby", 7'b11_1_0_1_1_0);
        pin_n = 1'b1;
        cyc(4);
        chk("R8 back to running", 7'b00_0_1_0_0_0);

        hold_cnt = 0;
        for (int i = 0; i < 4000; i++) begin
            sleep = ($urandom % 4) == 0;
            ssel  = $urandom % 2;
            lson  = ($urandom % 4) == 0;
            psel  = $urandom % 2;
            wake  = ($urandom % 6) == 0;
            if (hold_cnt > 0) hold_cnt--;
            else if (($urandom % 40) == 0 || !pin_n) begin
                pin_n    = ~pin_n;
                hold_cnt = 4 + ($urandom % 16);
            end
            cyc();
            chk(tag_of(m_m), exp_vec(m_m, tail_m));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule